// File: doc/BRIEF.md
# Serial Command Frame Walker

This block interprets a 64-byte command buffer that software has filled with a chain of small transactions for serial peripherals. When told to start, it checks a start marker in the last byte of the buffer. It then walks the buffer from offset 0. Each entry carries its own transmit length and receive length bytes. The walker gives each entry the next channel number and streams the entry's transmit bytes to the responder for that channel. The response bytes go back into the buffer in place, directly after the transmit bytes. A failed transaction is flagged inside the frame itself: bit 7 of that entry's receive length byte is set. At the end, the busy flag in the last byte is cleared and a one-cycle `done` pulse follows.

The buffer is an external single-port byte RAM. A read issued in one cycle returns its data on `buf_rdata` in the next cycle, and the RAM holds that data until the next read. Transmit bytes leave on a valid/ready request stream. `req_valid` stays high with `req_data`, `req_last`, `req_chan` and `req_rx_len` unchanged until `req_ready` is seen. Responses arrive on a valid/ready stream that the walker accepts only while `rsp_ready` is high. The first response beat of every entry is a verdict beat, in which only `rsp_fail` is meaningful. On success, exactly `req_rx_len` data beats follow it. On failure, nothing follows.

Top module: `cmd_frame_walker`

## Requirements
- R1: A `start` pulse in idle reads byte 63. A walk runs only if that byte equals 0x01. Any other value gives a `done` pulse with no buffer write and no request beat.
- R2: Length byte classes at the scan pointer. 0xFE ends the walk. Any other value with bit 7 set is skipped without changing the channel. A value of 0x00, or a value in 0x40..0x7F, moves to the next channel without consuming a receive length byte.
- R3: A length byte of 0x01..0x3F opens an entry. The next byte is its receive length, and 0xFE there ends the walk. Otherwise the transmit bytes that follow are sent in order on the request stream. Each beat carries the entry's channel number (counted from 0 per entry) and the receive count (receive length bits 5:0). `req_last` is set on the final beat.
- R4: On a passing verdict, the receive-count response bytes are written directly after the transmit bytes. The next entry starts after them.
- R5: An entry fails on a failing verdict, or when its channel is 5 or higher. In the second case no request beat is issued. A failure writes the receive length byte with bit 7 set and writes no response byte. The next entry starts right after the transmit bytes.
- R6: A new entry is read only while the scan pointer is below 63. A transmit byte at offset 64 or beyond is presented as 0x00, and a response byte that would land there is dropped. A response byte that lands on byte 63 is kept.
- R7: When a walk ends, byte 63 is re-read and written back with bit 7 cleared. `done` is high for exactly the one cycle after that write.
- R8: `start` has no effect from the cycle after an accepted start through the `done` cycle.
- R9: Stream and port rules. A request beat is held stable until `req_ready`. The channel on a request is always below 5. The buffer port never reads and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (sampled in idle) |
| done | output | 1 | One-cycle end-of-walk pulse |
| buf_addr | output | 6 | Buffer byte address |
| buf_rd | output | 1 | Buffer read strobe |
| buf_wr | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |
| buf_rdata | input | 8 | Buffer read data, one cycle after `buf_rd` |
| req_valid | output | 1 | Request beat valid |
| req_ready | input | 1 | Responder accepts the request beat |
| req_data | output | 8 | Transmit byte (first beat is the command code) |
| req_last | output | 1 | Final transmit byte of the entry |
| req_chan | output | 3 | Channel of the entry |
| req_rx_len | output | 6 | Expected number of response bytes |
| rsp_valid | input | 1 | Response beat valid |
| rsp_ready | output | 1 | Walker accepts the response beat |
| rsp_data | input | 8 | Response byte |
| rsp_fail | input | 1 | Verdict beat: transaction failed |

## Verification
Two functions can meet in one cycle. A new `start` can coincide with the `done` pulse of the walk before it. A response byte written into byte 63 can later meet the busy-flag clear of that same byte. The bench raises `start` exactly in the cycle where it sees `done`, and also in the middle of a walk. It then requires a single `done` and a buffer equal to one walk's result. A separate frame places an entry whose first response byte, with bit 7 set, lands on byte 63. The bench requires the final byte to be that response byte with bit 7 cleared, and requires `done` one cycle after that final write.

// File: rtl/cfw_pkg.sv
`timescale 1ns/1ps
package cfw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FLAG,
    ST_TX_LEN_RD,
    ST_TX_LEN,
    ST_RX_LEN,
    ST_TXB_RD,
    ST_TXB_OUT,
    ST_VERDICT,
    ST_RSP,
    ST_FAIL_WR,
    ST_END_RD,
    ST_END_WR,
    ST_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    LEN_END,
    LEN_SKIP,
    LEN_EMPTY,
    LEN_ENTRY
  } len_kind_e;

endpackage

// File: rtl/cfw_len_decode.sv
`timescale 1ns/1ps
module cfw_len_decode
  import cfw_pkg::*;
#(
  parameter logic [7:0] END_MARK = 8'hFE
) (
  input  logic [7:0] len_byte,
  output len_kind_e  kind
);

  always_comb begin
    if (len_byte == END_MARK)                 kind = LEN_END;
    else if (len_byte[7])                     kind = LEN_SKIP;
    else if (len_byte == 8'h00 || len_byte[6]) kind = LEN_EMPTY;
    else                                      kind = LEN_ENTRY;
  end

endmodule

// File: rtl/cfw_ptr_unit.sv
`timescale 1ns/1ps
module cfw_ptr_unit #(
  parameter int BUF_BYTES = 64,
  parameter int PTR_W     = 8,
  parameter int LEN_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             skip,
  input  logic [LEN_W-1:0] skip_len,
  output logic [PTR_W-1:0] ptr,
  output logic             in_buf,
  output logic             at_tail
);

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (clr)  ptr <= '0;
    else if (step) ptr <= ptr + PTR_W'(1);
    else if (skip) ptr <= ptr + PTR_W'(skip_len);
  end

  assign in_buf  = ptr < PTR_W'(BUF_BYTES);
  assign at_tail = ptr >= PTR_W'(BUF_BYTES - 1);

endmodule

// File: rtl/cmd_frame_walker.sv
`timescale 1ns/1ps
module cmd_frame_walker
  import cfw_pkg::*;
#(
  parameter int         BUF_BYTES = 64,
  parameter int         NUM_CHAN  = 5,
  parameter logic [7:0] START_VAL = 8'h01,
  parameter logic [7:0] END_MARK  = 8'hFE
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  output logic                          done,
  output logic [$clog2(BUF_BYTES)-1:0]  buf_addr,
  output logic                          buf_rd,
  output logic                          buf_wr,
  output logic [7:0]                    buf_wdata,
  input  logic [7:0]                    buf_rdata,
  output logic                          req_valid,
  input  logic                          req_ready,
  output logic [7:0]                    req_data,
  output logic                          req_last,
  output logic [$clog2(NUM_CHAN)-1:0]   req_chan,
  output logic [$clog2(BUF_BYTES)-1:0]  req_rx_len,
  input  logic                          rsp_valid,
  output logic                          rsp_ready,
  input  logic [7:0]                    rsp_data,
  input  logic                          rsp_fail
);

  localparam int ADDR_W = $clog2(BUF_BYTES);
  localparam int LEN_W  = ADDR_W;
  localparam int PTR_W  = ADDR_W + 2;
  localparam int CH_W   = ADDR_W + 1;
  localparam int CS_W   = $clog2(NUM_CHAN);
  localparam logic [ADDR_W-1:0] TAIL = ADDR_W'(BUF_BYTES - 1);

  walk_state_e       st, st_nx;
  len_kind_e         kind;
  logic [PTR_W-1:0]  ptr;
  logic              in_buf, at_tail;
  logic              p_clr, p_step, p_skip;
  logic [CH_W-1:0]   chan;
  logic [LEN_W-1:0]  tx_left, rx_left;
  logic [7:0]        rx_byte;
  logic [ADDR_W-1:0] rx_at;
  logic              oob;
  logic              chan_ok;

  cfw_len_decode #(.END_MARK(END_MARK)) u_len_decode (
    .len_byte (buf_rdata),
    .kind     (kind)
  );

  cfw_ptr_unit #(.BUF_BYTES(BUF_BYTES), .PTR_W(PTR_W), .LEN_W(LEN_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (p_clr),
    .step     (p_step),
    .skip     (p_skip),
    .skip_len (tx_left),
    .ptr      (ptr),
    .in_buf   (in_buf),
    .at_tail  (at_tail)
  );

  assign chan_ok    = chan < CH_W'(NUM_CHAN);
  assign req_valid  = (st == ST_TXB_OUT);
  assign req_data   = oob ? 8'h00 : buf_rdata;
  assign req_last   = (tx_left == LEN_W'(1));
  assign req_chan   = chan[CS_W-1:0];
  assign req_rx_len = rx_byte[LEN_W-1:0];
  assign rsp_ready  = (st == ST_VERDICT) || (st == ST_RSP);
  assign done       = (st == ST_DONE);

  always_comb begin
    st_nx     = st;
    buf_rd    = 1'b0;
    buf_wr    = 1'b0;
    buf_addr  = ptr[ADDR_W-1:0];
    buf_wdata = 8'h00;
    p_clr     = 1'b0;
    p_step    = 1'b0;
    p_skip    = 1'b0;
    case (st)
      ST_IDLE: if (start) begin
        buf_rd   = 1'b1;
        buf_addr = TAIL;
        st_nx    = ST_FLAG;
      end
      ST_FLAG: begin
        p_clr = (buf_rdata == START_VAL);
        st_nx = (buf_rdata == START_VAL) ? ST_TX_LEN_RD : ST_DONE;
      end
      ST_TX_LEN_RD: begin
        buf_rd = 1'b1;
        if (at_tail) begin
          buf_addr = TAIL;
          st_nx    = ST_END_WR;
        end else begin
          p_step = 1'b1;
          st_nx  = ST_TX_LEN;
        end
      end
      ST_TX_LEN: begin
        case (kind)
          LEN_END:   st_nx = ST_END_RD;
          LEN_ENTRY: begin
            buf_rd = 1'b1;
            p_step = 1'b1;
            st_nx  = ST_RX_LEN;
          end
          default:   st_nx = ST_TX_LEN_RD;
        endcase
      end
      ST_RX_LEN: begin
        if (buf_rdata == END_MARK) st_nx = ST_END_RD;
        else if (!chan_ok) begin
          p_skip = 1'b1;
          st_nx  = ST_FAIL_WR;
        end else st_nx = ST_TXB_RD;
      end
      ST_TXB_RD: begin
        buf_rd = in_buf;
        st_nx  = ST_TXB_OUT;
      end
      ST_TXB_OUT: if (req_ready) begin
        p_step = 1'b1;
        st_nx  = req_last ? ST_VERDICT : ST_TXB_RD;
      end
      ST_VERDICT: if (rsp_valid) begin
        if (rsp_fail)               st_nx = ST_FAIL_WR;
        else if (rx_left == '0)     st_nx = ST_TX_LEN_RD;
        else                        st_nx = ST_RSP;
      end
      ST_RSP: if (rsp_valid) begin
        buf_wr    = in_buf;
        buf_wdata = rsp_data;
        p_step    = 1'b1;
        if (rx_left == LEN_W'(1)) st_nx = ST_TX_LEN_RD;
      end
      ST_FAIL_WR: begin
        buf_wr    = 1'b1;
        buf_addr  = rx_at;
        buf_wdata = rx_byte | 8'h80;
        st_nx     = ST_TX_LEN_RD;
      end
      ST_END_RD: begin
        buf_rd   = 1'b1;
        buf_addr = TAIL;
        st_nx    = ST_END_WR;
      end
      ST_END_WR: begin
        buf_wr    = 1'b1;
        buf_addr  = TAIL;
        buf_wdata = buf_rdata & 8'h7F;
        st_nx     = ST_DONE;
      end
      ST_DONE: st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      chan    <= '0;
      tx_left <= '0;
      rx_left <= '0;
      rx_byte <= 8'h00;
      rx_at   <= '0;
      oob     <= 1'b0;
    end else begin
      st <= st_nx;
      case (st)
        ST_FLAG:    chan <= '0;
        ST_TX_LEN: begin
          if (kind == LEN_EMPTY) chan <= chan + CH_W'(1);
          if (kind == LEN_ENTRY) begin
            tx_left <= buf_rdata[LEN_W-1:0];
            rx_at   <= ptr[ADDR_W-1:0];
          end
        end
        ST_RX_LEN: if (buf_rdata != END_MARK) begin
          rx_byte <= buf_rdata;
          rx_left <= buf_rdata[LEN_W-1:0];
        end
        ST_TXB_RD:  oob <= !in_buf;
        ST_TXB_OUT: if (req_ready) tx_left <= tx_left - LEN_W'(1);
        ST_VERDICT: if (rsp_valid && !rsp_fail && rx_left == '0) chan <= chan + CH_W'(1);
        ST_RSP: if (rsp_valid) begin
          rx_left <= rx_left - LEN_W'(1);
          if (rx_left == LEN_W'(1)) chan <= chan + CH_W'(1);
        end
        ST_FAIL_WR: chan <= chan + CH_W'(1);
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cfw_checker.sv
`timescale 1ns/1ps
module cfw_checker #(
  parameter int BUF_BYTES = 64,
  parameter int NUM_CHAN  = 5
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         done,
  input logic                         buf_rd,
  input logic                         buf_wr,
  input logic [$clog2(BUF_BYTES)-1:0] buf_addr,
  input logic [7:0]                   buf_wdata,
  input logic                         req_valid,
  input logic                         req_ready,
  input logic [7:0]                   req_data,
  input logic                         req_last,
  input logic [$clog2(NUM_CHAN)-1:0]  req_chan
);

  localparam int ADDR_W = $clog2(BUF_BYTES);

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_data) &&
                                   $stable(req_last) && $stable(req_chan)));

  a_r9_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (int'(req_chan) < NUM_CHAN));

  a_r9_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_rd && buf_wr));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_busy_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(buf_wr)) |->
      ($past(buf_addr) == ADDR_W'(BUF_BYTES - 1) && !$past(buf_wdata[7])));

endmodule

bind cmd_frame_walker cfw_checker #(.BUF_BYTES(BUF_BYTES), .NUM_CHAN(NUM_CHAN)) u_cfw_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .buf_rd    (buf_rd),
  .buf_wr    (buf_wr),
  .buf_addr  (buf_addr),
  .buf_wdata (buf_wdata),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_data  (req_data),
  .req_last  (req_last),
  .req_chan  (req_chan)
);

// File: tb/test_cmd_frame_walker.sv
`timescale 1ns/1ps
module test_cmd_frame_walker;

  logic       clk = 1'b0;
  logic       rst_n, start, done;
  logic [5:0] buf_addr;
  logic       buf_rd, buf_wr;
  logic [7:0] buf_wdata, buf_rdata;
  logic       req_valid, req_ready, req_last;
  logic [7:0] req_data;
  logic [2:0] req_chan;
  logic [5:0] req_rx_len;
  logic       rsp_valid, rsp_ready, rsp_fail;
  logic [7:0] rsp_data;

  always #2.5 clk = ~clk;

  cmd_frame_walker i_cmd_frame_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .buf_addr(buf_addr), .buf_rd(buf_rd), .buf_wr(buf_wr),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
    .req_last(req_last), .req_chan(req_chan), .req_rx_len(req_rx_len),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_fail(rsp_fail)
  );

  int tests = 0, fails = 0, cyc = 0;
  int wr_cnt, done_cnt, done_cyc, last63_cyc;
  logic [7:0]  mem [64];
  logic [7:0]  img [64];
  logic [7:0]  ref_mem [64];
  logic        load_now = 1'b0;
  bit          fail_cfg [8];
  bit          exp_start;
  logic [17:0] exp_q [$];
  logic [8:0]  rsp_q [$];

  // Buffer RAM: registered read data, held until the next read.
  always @(posedge clk) begin
    if (load_now) begin
      for (int i = 0; i < 64; i++) mem[i] <= img[i];
    end else begin
      if (buf_rd) buf_rdata <= mem[buf_addr];
      if (buf_wr) mem[buf_addr] <= buf_wdata;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] resp_byte(int ch, logic [7:0] code, int i);
    return {1'b1, 7'(code * 3 + ch * 16 + i)};
  endfunction

  function automatic logic [7:0] rd_ref(int a);
    return (a < 64) ? ref_mem[a] : 8'h00;
  endfunction

  // Behavioural reference of one walk over the staged image.
  task automatic model_frame();
    int p, ch, t, r, n, rx_at;
    logic [7:0] code;
    bit f;
    for (int i = 0; i < 64; i++) ref_mem[i] = img[i];
    exp_q.delete();
    exp_start = (img[63] == 8'h01);
    if (!exp_start) return;
    p = 0; ch = 0;
    while (p < 63) begin
      t = int'(ref_mem[p]); p++;
      if (t == 8'hFE) break;
      if (t >= 8'h80) continue;
      if (t == 0 || t >= 8'h40) begin ch++; continue; end
      rx_at = p; r = int'(ref_mem[p]); p++;
      if (r == 8'hFE) break;
      n = r % 64;
      code = rd_ref(p);
      f = (ch >= 5) || fail_cfg[ch];
      if (ch < 5)
        for (int i = 0; i < t; i++)
          exp_q.push_back({3'(ch), 6'(n), rd_ref(p + i), 1'(i == t - 1)});
      p += t;
      if (f) ref_mem[rx_at] = 8'(r) | 8'h80;
      else begin
        for (int i = 0; i < n; i++) if (p + i < 64) ref_mem[p + i] = resp_byte(ch, code, i);
        p += n;
      end
      ch++;
    end
    ref_mem[63] &= 8'h7F;
  endtask

  // Responder and monitor, acting between clock edges.
  initial begin
    logic [7:0] cur_code;
    logic [17:0] e;
    bit take = 1'b0;
    int bidx = 0;
    rsp_valid = 1'b0; rsp_data = 8'h00; rsp_fail = 1'b0; req_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) continue;
      if (take) void'(rsp_q.pop_front());
      if (rsp_q.size() > 0 && (cyc % 3) != 0) begin
        rsp_valid = 1'b1;
        {rsp_fail, rsp_data} = rsp_q[0];
      end else begin
        rsp_valid = 1'b0;
      end
      take = rsp_valid && rsp_ready;
      req_ready = (cyc % 4) != 1;
      if (req_valid && req_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R3", "unexpected request beat", int'(req_data), 0);
        else begin
          e = exp_q.pop_front();
          check({req_chan, req_rx_len, req_data, req_last} == e, "R3", "request beat",
                int'({req_chan, req_rx_len, req_data, req_last}), int'(e));
        end
        if (bidx == 0) cur_code = req_data;
        bidx++;
        if (req_last) begin
          rsp_q.push_back({fail_cfg[req_chan], 8'h00});
          if (!fail_cfg[req_chan])
            for (int i = 0; i < int'(req_rx_len); i++)
              rsp_q.push_back({1'b0, resp_byte(int'(req_chan), cur_code, i)});
          bidx = 0;
        end
      end
      if (done) begin done_cnt++; done_cyc = cyc; end
      if (buf_wr) begin
        wr_cnt++;
        if (buf_addr == 6'd63) last63_cyc = cyc;
      end
    end
  end

  task automatic run_frame(string tag, bit poke);
    int n = 0;
    model_frame();
    @(negedge clk) load_now = 1'b1;
    @(negedge clk) load_now = 1'b0;
    wr_cnt = 0; done_cnt = 0; done_cyc = -1; last63_cyc = -1;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      @(negedge clk) start = 1'b1;   // R8: mid-walk start
      @(negedge clk) start = 1'b0;
    end
    while (!done && n < 5000) begin @(negedge clk); n++; end
    if (poke && done) start = 1'b1;  // R8: start in the done cycle
    @(negedge clk) start = 1'b0;
    repeat (12) @(negedge clk);
    check(done_cnt == 1, "R8", {tag, " done count"}, done_cnt, 1);
    check(exp_q.size() == 0, "R3", {tag, " beats left"}, exp_q.size(), 0);
    check(rsp_q.size() == 0, "R4", {tag, " responses left"}, rsp_q.size(), 0);
    for (int i = 0; i < 64; i++)
      check(mem[i] === ref_mem[i], "R4/R5", $sformatf("%s byte %0d", tag, i),
            int'(mem[i]), int'(ref_mem[i]));
    if (!exp_start) check(wr_cnt == 0, "R1", {tag, " writes"}, wr_cnt, 0);
    else check(done_cyc == last63_cyc + 1, "R7", {tag, " done after clear"}, done_cyc, last63_cyc + 1);
  endtask

  task automatic fill(logic [7:0] v);
    for (int i = 0; i < 64; i++) img[i] = v;
    for (int i = 0; i < 8; i++) fail_cfg[i] = 1'b0;
  endtask

  task automatic put(int a, logic [7:0] v);
    img[a] = v;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic frame_a(bit poke);
    fill(8'h00);
    put(0, 8'h01); put(1, 8'h04); put(2, 8'h01);                       // ch0 ok
    put(7, 8'h00);                                                     // ch1 empty
    put(8, 8'h02); put(9, 8'h03); put(10, 8'h07); put(11, 8'hAA);      // ch2 ok
    put(15, 8'h01); put(16, 8'h02); put(17, 8'h09);                    // ch3 fails
    put(18, 8'h01); put(19, 8'h02); put(20, 8'h0C);                    // ch4 ok
    put(23, 8'hFE); put(63, 8'h01);
    fail_cfg[3] = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0;
    repeat (4) @(negedge clk);
    check(done == 1'b0, "R7", "reset done", int'(done), 0);
    check(req_valid == 1'b0, "R9", "reset req_valid", int'(req_valid), 0);
    check(buf_wr == 1'b0 && buf_rd == 1'b0, "R1", "reset buffer port", int'({buf_rd, buf_wr}), 0);
    check(rsp_ready == 1'b0, "R9", "reset rsp_ready", int'(rsp_ready), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R4 R5: mixed entries, verdict failure, in-place write-back
    frame_a(1'b0);
    run_frame("frameA", 1'b0);

    // R2 R5: skip bytes, empty channels, zero receive count, channel 5 without responder
    fill(8'h00);
    put(0, 8'hFF); put(1, 8'h80); put(2, 8'h00); put(3, 8'h45);
    put(4, 8'h00); put(5, 8'h00);
    put(6, 8'h01); put(7, 8'h00); put(8, 8'h05);
    put(9, 8'h01); put(10, 8'h02); put(11, 8'h06);
    put(12, 8'hFE); put(63, 8'h01);
    run_frame("frameB", 1'b0);

    // R3: receive length terminator
    fill(8'h00);
    put(0, 8'h01); put(1, 8'hFE); put(2, 8'h05); put(63, 8'h01);
    run_frame("frameC", 1'b0);

    // R6: transmit read past the buffer, response writes dropped
    fill(8'h80);
    put(58, 8'h05); put(59, 8'h02); put(60, 8'h11); put(61, 8'h22); put(62, 8'h33);
    put(63, 8'h01);
    run_frame("frameD1", 1'b0);

    // R6 R7: response lands on byte 63 with bit 7 set, then busy clear
    fill(8'h80);
    put(60, 8'h01); put(61, 8'h03); put(62, 8'h05); put(63, 8'h01);
    run_frame("frameD2", 1'b0);

    // R6: full scan of empty entries up to the tail
    fill(8'h00);
    put(63, 8'h01);
    run_frame("frameE", 1'b0);

    // R1: no start marker
    frame_a(1'b0);
    put(63, 8'h00);
    run_frame("frameF0", 1'b0);
    frame_a(1'b0);
    put(63, 8'h81);
    run_frame("frameF1", 1'b0);

    // R8: extra starts mid-walk and in the done cycle
    frame_a(1'b0);
    fail_cfg[0] = 1'b1;
    run_frame("frameG", 1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule